// File: doc/BRIEF.md
# Run-Length Timestamped Sample Cluster Packer

This block sits between a capture front end and a row-organised sample memory. On every sample tick it receives one 16-bit word of pin levels. When the levels are the same as on the previous tick, nothing is stored. When they differ, the block opens a cluster. A cluster is eight memory words: one 16-bit timestamp and then seven sample words. These samples are taken on consecutive ticks, so the k-th sample (counting from zero) belongs to the timestamp plus k.

The timestamp is a free-running 16-bit count of ticks. A cluster is also forced exactly 65536 ticks after the previous one opened, whether or not the pins changed, so a reader can tell how many times the timestamp rolled over.

Writes leave the block as single-cycle requests, each carrying a word address and a data word. The address has a row part and a column part: with the default widths there are 32768 rows of 512 words each, 64 clusters per row. The address counter wraps from the last word back to word 0 and raises a sticky flag when it does. The next free address is presented continuously as the stop position.

The sample tick is a strobe. It must never be high on two consecutive clocks. The clock that follows an opening tick is used for the cluster's first sample word.

Top module: `rle_cluster_packer`

## Requirements
- R1: After reset there are no write requests, the stop position is 0, the wrap flag is 0, and the comparison reference for change detection is 16'h0000.
- R2: On a tick with no open cluster, a sample equal to the previous tick's sample causes no write, unless R6 applies.
- R3: On a tick with no open cluster, a sample that differs from the previous tick's sample opens a cluster. The clock after that tick writes the timestamp word, which is the number of ticks since reset modulo 65536 (the first tick is 0). The clock after that writes the tick's sample.
- R4: After an opening tick, each of the next six ticks writes its own sample, changed or not, so every cluster is exactly eight words. Pin changes during those ticks do not open a new cluster.
- R5: The tick right after a cluster's seventh sample is again examined for a change, so clusters can follow back to back.
- R6: A cluster opens on the tick exactly 65536 ticks after the previous opening tick, even with no pin change.
- R7: Write addresses run consecutively from 0, and every timestamp word lands on an address whose low three bits are 000.
- R8: The stop position equals the address of the latest write plus one. It changes on the same clock as the write request and holds otherwise.
- R9: The address after the all-ones address is 0. The wrap flag rises on the same clock as the write to the all-ones address and then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_tick | input | 1 | Sample strobe, never high on two consecutive clocks |
| smp_data | input | 16 | Pin levels for this tick |
| mem_we | output | 1 | Write request, one clock per word |
| mem_addr | output | ROW_BITS+COL_BITS | Word address of the write |
| mem_wdata | output | 16 | Timestamp or sample word |
| stop_pos | output | ROW_BITS+COL_BITS | Next address to be written |
| wrap_seen | output | 1 | Sticky: the address has wrapped |

## Verification
A wrong event counter shows up within one tick. Either a write appears on a quiet tick, or a sample write is missing, or the next timestamp word lands on an address whose low three bits are not 000. A wrong change reference or a bad opening decision is visible on the very tick involved. That tick either produces two writes where none were due, or none where two were due.

A fault in the rollover counter shows only at the 65536th quiet tick, so the bench runs one full quiet span. Address and wrap faults show as a break in the address sequence, or as a wrap flag that does not rise on the clock that writes the last address. To reach that point in reasonable time, the bench instance uses a memory with two rows.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
    localparam int WORD_W             = 16;
    localparam int TS_W               = 16;
    localparam int EVENTS_PER_CLUSTER = 7;
    localparam int LEFT_W             = $clog2(EVENTS_PER_CLUSTER + 1);
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rlp_stamp_gen.sv
// Tick timestamp plus a counter of ticks since the last cluster opened.
module rlp_stamp_gen
    import rlp_pkg::*;
#(
    parameter int GAP_TICKS = 1 << TS_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            opened,
    output logic [TS_W-1:0] ts,
    output logic            force_open
);
    localparam int GW = $clog2(GAP_TICKS);

    logic [TS_W-1:0] ts_d, ts_q;
    logic [GW-1:0]   gap_d, gap_q;

    always_comb begin
        ts_d  = ts_q;
        gap_d = gap_q;
        if (tick) begin
            ts_d  = ts_q + 1'b1;
            gap_d = opened ? '0 : gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q  <= '0;
            gap_q <= '0;
        end else begin
            ts_q  <= ts_d;
            gap_q <= gap_d;
        end
    end

    assign ts         = ts_q;
    assign force_open = (gap_q == GW'(GAP_TICKS - 1));
endmodule

// File: rtl/rlp_addr_gen.sv
// Next-free word address with natural wrap and a sticky wrap flag.
module rlp_addr_gen #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [ADDR_W-1:0] next_addr,
    output logic              wrapped
);
    logic [ADDR_W-1:0] next_d, next_q;
    logic              wrap_d, wrap_q;

    always_comb begin
        next_d = next_q;
        wrap_d = wrap_q;
        if (advance) begin
            next_d = next_q + 1'b1;
            if (next_q == '1) wrap_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            next_q <= next_d;
            wrap_q <= wrap_d;
        end
    end

    assign next_addr = next_q;
    assign wrapped   = wrap_q;
endmodule

// File: rtl/rle_cluster_packer.sv
module rle_cluster_packer
    import rlp_pkg::*;
#(
    parameter int ROW_BITS  = 15,
    parameter int COL_BITS  = 9,
    parameter int GAP_TICKS = 1 << TS_W,
    localparam int ADDR_W   = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic [WORD_W-1:0] smp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] stop_pos,
    output logic              wrap_seen
);
    typedef struct packed {
        logic [LEFT_W-1:0] left;   // sample words still owed to the open cluster
        logic              pend;   // first sample word goes out this clock
        word_t             hold;   // opening tick's sample
        word_t             prev;   // previous tick's sample
        logic              we;
        word_t             wdata;
        logic [ADDR_W-1:0] waddr;
    } state_t;

    state_t            s_d, s_q;
    logic [TS_W-1:0]   ts_now;
    logic              force_open;
    logic              open_now;
    logic              wr_now;
    logic [ADDR_W-1:0] next_addr;

    rlp_stamp_gen #(.GAP_TICKS(GAP_TICKS)) u_stamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (smp_tick),
        .opened     (open_now),
        .ts         (ts_now),
        .force_open (force_open)
    );

    rlp_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (wr_now),
        .next_addr (next_addr),
        .wrapped   (wrap_seen)
    );

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        open_now = 1'b0;
        if (s_q.pend) begin
            s_d.we    = 1'b1;
            s_d.wdata = s_q.hold;
            s_d.pend  = 1'b0;
        end else if (smp_tick) begin
            s_d.prev = smp_data;
            if (s_q.left != '0) begin
                s_d.we    = 1'b1;
                s_d.wdata = smp_data;
                s_d.left  = s_q.left - 1'b1;
            end else if ((smp_data != s_q.prev) || force_open) begin
                open_now  = 1'b1;
                s_d.we    = 1'b1;
                s_d.wdata = word_t'(ts_now);
                s_d.hold  = smp_data;
                s_d.pend  = 1'b1;
                s_d.left  = LEFT_W'(EVENTS_PER_CLUSTER - 1);
            end
        end
        if (s_d.we) s_d.waddr = next_addr;
        wr_now = s_d.we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_we    = s_q.we;
    assign mem_addr  = s_q.waddr;
    assign mem_wdata = s_q.wdata;
    assign stop_pos  = next_addr;
endmodule

// File: rtl/rlp_checker.sv
module rlp_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_tick,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] stop_pos,
    input logic              wrap_seen
);
    // R3: usage rule that leaves the next clock free for the first sample word
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |=> !smp_tick);

    // R3: a timestamp word is followed at once by the first sample word
    p_ts_then_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr[2:0] == 3'd0) |=> mem_we);

    // R7: back-to-back writes use consecutive addresses
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R8: stop position is one past the write address
    p_stop_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (stop_pos == ADDR_W'(mem_addr + 1'b1)));

    // R8: stop position holds without a write
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> $stable(stop_pos));

    // R9: wrap flag is sticky
    p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_seen |=> wrap_seen);

    // R9: wrap flag rises with the write to the last address
    p_wrap_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_seen) |-> (mem_we && mem_addr == '1 && stop_pos == '0));
endmodule

bind rle_cluster_packer rlp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_tick  (smp_tick),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .stop_pos  (stop_pos),
    .wrap_seen (wrap_seen)
);

// File: tb/sim_rle_cluster_packer.sv
module sim_rle_cluster_packer;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_BITS   = 1;
    localparam int COL_BITS   = 9;
    localparam int AW         = ROW_BITS + COL_BITS;
    localparam int K_NONE = 0, K_EV = 1, K_OPEN = 2;

    // {sample, expected kind: 0 none, 1 sample write, 2 cluster open}
    localparam logic [17:0] VEC [25] = '{
        {16'h0000, 2'd0}, {16'h1234, 2'd2}, {16'h1234, 2'd1}, {16'h1234, 2'd1},
        {16'h0005, 2'd1}, {16'h0005, 2'd1}, {16'h0006, 2'd1}, {16'h0007, 2'd1},
        {16'h0007, 2'd0}, {16'h0007, 2'd0}, {16'h00FF, 2'd2}, {16'h0100, 2'd1},
        {16'h0100, 2'd1}, {16'h0100, 2'd1}, {16'h0200, 2'd1}, {16'h0300, 2'd1},
        {16'hAAAA, 2'd1}, {16'h5555, 2'd2}, {16'h5555, 2'd1}, {16'h5555, 2'd1},
        {16'h5555, 2'd1}, {16'h5555, 2'd1}, {16'h5555, 2'd1}, {16'h5555, 2'd1},
        {16'h5555, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_tick = 1'b0;
    logic [15:0]   smp_data = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [AW-1:0] stop_pos;
    logic          wrap_seen;

    int            total = 0;
    int            fails = 0;
    int            tix = 0;
    int            last_open = -1000000;
    int            m_left = 0;
    logic [15:0]   m_prev = '0;
    logic [AW-1:0] exp_addr = '0;
    logic          exp_wrap = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rle_cluster_packer #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .smp_data(smp_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .stop_pos(stop_pos), .wrap_seen(wrap_seen)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h (tick %0d)", tag, act, exp, tix);
        end
    endtask

    task automatic observe(input int kind, input int slot, input logic [15:0] v, input string tag);
        logic          exp_we;
        logic [15:0]   exp_d;
        logic [AW-1:0] exp_stop;
        exp_we = (kind == K_OPEN) || (kind == K_EV && slot == 0);
        exp_d  = (kind == K_OPEN && slot == 0) ? tix[15:0] : v;
        check(mem_we === exp_we, tag, 32'(mem_we), 32'(exp_we));
        if (exp_we) begin
            check(mem_wdata == exp_d, tag, 32'(mem_wdata), 32'(exp_d));
            check(mem_addr == exp_addr, "R7 address", 32'(mem_addr), 32'(exp_addr));
            if (kind == K_OPEN && slot == 0)
                check(mem_addr[2:0] == 3'd0, "R7 timestamp alignment", 32'(mem_addr[2:0]), 32'd0);
            if (exp_addr == '1) exp_wrap = 1'b1;
            exp_addr = exp_addr + 1'b1;
        end
        exp_stop = exp_addr;
        check(stop_pos == exp_stop, "R8 stop position", 32'(stop_pos), 32'(exp_stop));
        check(wrap_seen == exp_wrap, "R9 wrap flag", 32'(wrap_seen), 32'(exp_wrap));
    endtask

    // Drive one tick at a negedge, observe the two clocks that follow it.
    task automatic run_tick(input logic [15:0] v, input int kind, input string tag);
        smp_tick = 1'b1;
        smp_data = v;
        @(negedge clk);
        smp_tick = 1'b0;
        observe(kind, 0, v, tag);
        @(negedge clk);
        observe(kind, 1, v, tag);
        if (kind == K_OPEN) begin
            m_left    = 6;
            last_open = tix;
        end else if (kind == K_EV) begin
            m_left--;
        end
        m_prev = v;
        tix++;
    endtask

    function automatic int kind_of(input logic [15:0] v);
        if (m_left > 0) return K_EV;
        if (v != m_prev || (tix - last_open) == 65536) return K_OPEN;
        return K_NONE;
    endfunction

    function automatic string tag_of(input int kind, input logic [15:0] v);
        if (kind == K_OPEN) return (v == m_prev) ? "R6 forced cluster" : "R3 cluster open";
        if (kind == K_EV) return "R4 cluster sample";
        return "R2 quiet tick";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_we == 1'b0, "R1 reset write", 32'(mem_we), 32'd0);
        check(stop_pos == '0, "R1 reset stop", 32'(stop_pos), 32'd0);
        check(wrap_seen == 1'b0, "R1 reset wrap", 32'(wrap_seen), 32'd0);

        // vector table: quiet ticks, openings, full clusters, back-to-back (R5)
        for (int i = 0; i < 25; i++) begin
            int k;
            k = int'(VEC[i][1:0]);
            if (i == 17)            run_tick(VEC[i][17:2], k, "R5 back-to-back open");
            else if (i == 0)        run_tick(VEC[i][17:2], k, "R1 reset reference");
            else if (k == K_OPEN)   run_tick(VEC[i][17:2], k, "R3 cluster open");
            else if (k == K_EV)     run_tick(VEC[i][17:2], k, "R4 cluster sample");
            else                    run_tick(VEC[i][17:2], k, "R2 quiet tick");
        end

        // R6: constant input until the forced cluster, then its samples
        while (tix < 17 + 65536 + 7) begin
            int k;
            k = kind_of(16'h5555);
            run_tick(16'h5555, k, tag_of(k, 16'h5555));
        end

        // R9: changing input every tick until the address wraps
        for (int n = 0; n < 1400 && !(exp_wrap && exp_addr >= 16); n++) begin
            logic [15:0] v;
            int k;
            v = tix[15:0] ^ 16'h8000;
            k = kind_of(v);
            run_tick(v, k, tag_of(k, v));
        end
        check(exp_wrap == 1'b1, "R9 wrap reached", 32'(exp_wrap), 32'd1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule